// File: doc/BRIEF.md
# GPIO Port with Transition Interrupts

This block is one general-purpose I/O port of parameterised width, controlled through a small register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Each pin has its own settings:
- a direction bit;
- a polarity-inversion bit, which applies to both the sampled input and the driven output;
- an output style, either a steady level or a one-shot pulse of fixed width.

Inputs pass through a two-flop synchronizer. Any change on a pin configured as input is then recorded in a transition status register, which clears when it is read.

The status bits are gated by per-pin enables and drive an interrupt line. The interrupt has two modes. In level mode it stays active until the status is read. In pulse mode it emits single-cycle pulses at a fixed interval for as long as enabled status remains pending. The idle polarity of the line is programmable. The interrupt can also be routed onto one designated GPIO pin. That pin then stops acting as a GPIO, and its status bit reads zero. The serial bus front end and the electrical pin drivers sit outside this block.

Top module: `gpio_xport`

## Requirements
- R1: After reset the registers read as follows. Direction (address 3) reads all ones, so every pin is an input. Polarity (address 2) reads `POL_RST`. Output data (1), output style (4), interrupt enable (6), mode (7) and status (5) all read zero. `int_o` is low.
- R2: `pin_oe[i]` is 1 exactly when direction bit i is 0 (output). The only exception is the designated INT pin while it carries the interrupt.
- R3: A read of address 0 returns the synchronized pin levels XOR the polarity register.
- R4: In level style (style bit 0), `pin_out[i]` equals output data bit i XOR polarity bit i. A read of address 1 returns the stored output data, not the pin level.
- R5: When style bit i is 1, writing a 1 to output data bit i makes `pin_out[i]` active for exactly `PULSE_W` cycles, then idle. Active is NOT polarity bit i; idle is the polarity bit.
- R6: A rising or falling transition on a pin whose direction bit is 1 sets its bit in the status register (address 5). Transitions on output pins set nothing.
- R7: A read of address 5 returns the status and clears every bit. A transition that is recorded in the same cycle as that read stays set.
- R8: A status bit whose enable bit (address 6) is 0 does not activate the interrupt.
- R9: With mode bit 1 = 0 (level mode), the interrupt stays active while any enabled status bit is set, and it goes idle after the status read.
- R10: With mode bit 1 = 1 (pulse mode), the interrupt is active for single cycles, repeating every `INT_REPEAT` cycles while enabled status is pending, and stays idle once the status is cleared.
- R11: Mode bit 2 sets the idle polarity of `int_o`. A 1 means idle high and active low; a 0 means idle low and active high.
- R12: With mode bit 0 = 1, pin `INT_PIN` drives the interrupt level (`pin_oe` set, `pin_out` equal to `int_o`), and its status bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wdata | input | WIDTH | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | WIDTH | Read data, registered on a read strobe |
| pin_i | input | WIDTH | Pin input levels |
| pin_out | output | WIDTH | Pin output values |
| pin_oe | output | WIDTH | Pin output enables |
| int_o | output | 1 | Interrupt line |

## Verification
The bench builds the port with 8 pins, a polarity reset of 0xF0, `PULSE_W` = 3, `INT_REPEAT` = 6 and the INT pin at bit 7. The short pulse width lets every cycle of a GPO pulse be counted. The short repeat interval fits several interrupt re-fires into one window, so their spacing and single-cycle width can be checked. The bench also lines up a pin transition with a status read on the same clock edge, to show that the new event survives the clear.

// File: rtl/gpio_xport_pkg.sv
package gpio_xport_pkg;
  typedef enum logic [2:0] {
    A_IN   = 3'd0,
    A_OUT  = 3'd1,
    A_POL  = 3'd2,
    A_DIR  = 3'd3,
    A_STY  = 3'd4,
    A_STAT = 3'd5,
    A_IEN  = 3'd6,
    A_MODE = 3'd7
  } reg_addr_e;

  localparam int MODE_W     = 3;
  localparam int M_INT_PIN  = 0;
  localparam int M_PULSE    = 1;
  localparam int M_IDLE_HI  = 2;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign sync_o = s2_q;
  assign edge_o = s2_q ^ s3_q;
endmodule

// File: rtl/gpio_pulse_gen.sv
module gpio_pulse_gen #(
  parameter int W       = 8,
  parameter int PULSE_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fire_i,
  output logic [W-1:0] active_o
);
  localparam int CW = $clog2(PULSE_W + 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst)
        cnt_q <= '0;
      else if (fire_i[i])
        cnt_q <= CW'(PULSE_W);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end

    assign active_o[i] = (cnt_q != '0);

    // R5
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
      fire_i[i] |=> active_o[i]);
  end
endmodule

// File: rtl/gpio_int_ctrl.sv
module gpio_int_ctrl #(
  parameter int W      = 8,
  parameter int REPEAT = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] ien_i,
  input  logic         pulse_mode_i,
  input  logic         idle_high_i,
  output logic         int_o
);
  localparam int CW = $clog2(REPEAT + 1);

  logic          pending;
  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign pending = |(status_i & ien_i);

  always_comb begin
    act_n = 1'b0;
    cnt_n = '0;
    if (pending) begin
      if (!pulse_mode_i) begin
        act_n = 1'b1;
      end else if (cnt_q == '0) begin
        act_n = 1'b1;
        cnt_n = CW'(REPEAT - 1);
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      int_o <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      int_o <= act_n ^ idle_high_i;
    end
  end

  // R8
  no_pend_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pending |=> !act_q);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode_i && $past(pulse_mode_i) && act_q) |=> !act_q);

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pulse_mode_i && pending) |=> act_q);
endmodule

// File: rtl/gpio_xport.sv
module gpio_xport
  import gpio_xport_pkg::*;
#(
  parameter int             WIDTH      = 8,
  parameter logic [WIDTH-1:0] POL_RST  = 8'hF0,
  parameter int             PULSE_W    = 4,
  parameter int             INT_REPEAT = 16,
  parameter int             INT_PIN    = WIDTH - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             we,
  input  logic             re,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic             int_o
);
  logic [WIDTH-1:0]  dir_q, pol_q, out_q, sty_q, ien_q, stat_q, stat_n;
  logic [MODE_W-1:0] mode_q;
  logic [WIDTH-1:0]  sync_v, edge_v, set_v, int_mask, fire_v, pulse_v, gp_val;
  logic              rd_stat;

  gpio_sync_edge #(.W(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .sync_o(sync_v), .edge_o(edge_v)
  );

  assign fire_v = (we && addr == A_OUT) ? (wdata & sty_q) : '0;

  gpio_pulse_gen #(.W(WIDTH), .PULSE_W(PULSE_W)) u_pulse (
    .clk(clk), .rst(rst), .fire_i(fire_v), .active_o(pulse_v)
  );

  gpio_int_ctrl #(.W(WIDTH), .REPEAT(INT_REPEAT)) u_int (
    .clk(clk), .rst(rst), .status_i(stat_q), .ien_i(ien_q),
    .pulse_mode_i(mode_q[M_PULSE]), .idle_high_i(mode_q[M_IDLE_HI]),
    .int_o(int_o)
  );

  assign int_mask = mode_q[M_INT_PIN] ? (WIDTH'(1) << INT_PIN) : '0;
  assign rd_stat  = re && addr == A_STAT;
  assign set_v    = edge_v & dir_q & ~int_mask;
  assign stat_n   = ((rd_stat ? '0 : stat_q) | set_v) & ~int_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      pol_q  <= POL_RST;
      out_q  <= '0;
      sty_q  <= '0;
      ien_q  <= '0;
      mode_q <= '0;
      stat_q <= '0;
      rdata  <= '0;
    end else begin
      stat_q <= stat_n;
      if (we) begin
        case (addr)
          A_OUT:   out_q  <= wdata;
          A_POL:   pol_q  <= wdata;
          A_DIR:   dir_q  <= wdata;
          A_STY:   sty_q  <= wdata;
          A_IEN:   ien_q  <= wdata;
          A_MODE:  mode_q <= wdata[MODE_W-1:0];
          default: ;
        endcase
      end
      if (re) begin
        case (addr)
          A_IN:    rdata <= sync_v ^ pol_q;
          A_OUT:   rdata <= out_q;
          A_POL:   rdata <= pol_q;
          A_DIR:   rdata <= dir_q;
          A_STY:   rdata <= sty_q;
          A_STAT:  rdata <= stat_q;
          A_IEN:   rdata <= ien_q;
          default: rdata <= WIDTH'(mode_q);
        endcase
      end
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_drv
    assign gp_val[i] = (sty_q[i] ? pulse_v[i] : out_q[i]) ^ pol_q[i];
    if (i == INT_PIN) begin : g_intpin
      assign pin_out[i] = mode_q[M_INT_PIN] ? int_o : gp_val[i];
      assign pin_oe[i]  = mode_q[M_INT_PIN] | ~dir_q[i];
    end else begin : g_plain
      assign pin_out[i] = gp_val[i];
      assign pin_oe[i]  = ~dir_q[i];
    end
  end

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && set_v == '0) |=> stat_q == '0);

  // R7
  edge_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((stat_q & $past(set_v)) == $past(set_v)));

  // R12
  int_pin_stat_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q[M_INT_PIN] |=> !stat_q[INT_PIN]);
endmodule

// File: tb/gpio_xport_bench.sv
module gpio_xport_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic         we = 1'b0;
  logic         re = 1'b0;
  logic [W-1:0] rdata;
  logic [W-1:0] pin_i = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         int_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_xport #(.WIDTH(W), .POL_RST(8'hF0), .PULSE_W(3), .INT_REPEAT(6), .INT_PIN(7))
  u_gpio_xport (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .pin_i(pin_i), .pin_out(pin_out), .pin_oe(pin_oe), .int_o(int_o)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    rd(3, d); check("R1 dir", d, 8'hFF);
    rd(2, d); check("R1 pol", d, 8'hF0);
    rd(1, d); check("R1 out", d, 8'h00);
    rd(4, d); check("R1 style", d, 8'h00);
    rd(6, d); check("R1 ien", d, 8'h00);
    rd(7, d); check("R1 mode", d, 8'h00);
    rd(5, d); check("R1 status", d, 8'h00);
    check("R1 int_o", W'(int_o), 8'h00);
    check("R2 oe reset", pin_oe, 8'h00);
  endtask

  task automatic t_input();
    logic [W-1:0] d;
    @(negedge clk); pin_i = 8'hA5;
    idle(4);
    rd(0, d); check("R3 input xor pol", d, 8'h55);
    wr(2, 8'h00);
    rd(0, d); check("R3 input no pol", d, 8'hA5);
    rd(5, d); check("R6 input transitions", d, 8'hA5);
    rd(5, d); check("R7 cleared by read", d, 8'h00);
  endtask

  task automatic t_level_out();
    logic [W-1:0] d;
    wr(3, 8'h0F);
    wr(1, 8'hA0);
    wr(2, 8'h30);
    check("R2 oe", pin_oe, 8'hF0);
    check("R4 level out", pin_out & 8'hF0, 8'h90);
    rd(1, d); check("R4 out readback", d, 8'hA0);
    @(negedge clk); pin_i = 8'h55;
    idle(5);
    rd(5, d); check("R6 output pins ignored", d, 8'h00);
  endtask

  task automatic t_pulse_out();
    logic [W-1:0] d;
    int hi;
    wr(2, 8'h00);
    wr(1, 8'h00);
    wr(4, 8'h10);
    check("R5 idle before", W'(pin_out[4]), 8'h00);
    wr(1, 8'h10);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      if (pin_out[4]) hi++;
      @(negedge clk);
    end
    check("R5 pulse width", W'(hi), 8'd3);
    rd(1, d); check("R4 flop not pin", d, 8'h10);
    wr(4, 8'h00);
    wr(1, 8'h00);
  endtask

  task automatic t_int_level();
    logic [W-1:0] d;
    wr(3, 8'hFF);
    @(negedge clk); pin_i = 8'h00;
    idle(5);
    rd(5, d);
    wr(6, 8'h01);
    wr(7, 8'h00);
    @(negedge clk); pin_i = 8'h02;
    idle(6);
    check("R8 disabled pin no int", W'(int_o), 8'h00);
    rd(5, d); check("R6 pin1 status", d, 8'h02);
    @(negedge clk); pin_i = 8'h03;
    idle(6);
    check("R9 level active", W'(int_o), 8'h01);
    idle(10);
    check("R9 level held", W'(int_o), 8'h01);
    rd(5, d); check("R9 status", d, 8'h01);
    idle(2);
    check("R9 idle after read", W'(int_o), 8'h00);
  endtask

  task automatic t_int_pulse();
    logic [W-1:0] d;
    int lows, dbl;
    logic prev;
    wr(7, 8'h06);
    idle(2);
    check("R11 idle high", W'(int_o), 8'h01);
    @(negedge clk); pin_i = 8'h02;
    idle(4);
    lows = 0; dbl = 0; prev = 1'b1;
    for (int k = 0; k < 30; k++) begin
      if (!int_o) begin
        lows++;
        if (!prev) dbl++;
      end
      prev = int_o;
      @(negedge clk);
    end
    check("R10 repeat count", W'(lows >= 4 && lows <= 6), 8'h01);
    check("R10 single cycle", W'(dbl), 8'h00);
    rd(5, d);
    idle(3);
    lows = 0;
    for (int k = 0; k < 20; k++) begin
      if (!int_o) lows++;
      @(negedge clk);
    end
    check("R10 quiet after read", W'(lows), 8'h00);
  endtask

  task automatic t_int_pin();
    logic [W-1:0] d;
    wr(7, 8'h01);
    idle(2);
    check("R12 pin oe", W'(pin_oe[7]), 8'h01);
    @(negedge clk); pin_i = 8'h83;
    idle(6);
    check("R12 pin carries int", W'(pin_out[7]), 8'h01);
    check("R12 pin equals int_o", W'(pin_out[7]), W'(int_o));
    rd(5, d); check("R12 status bit7 zero", d, 8'h01);
    idle(2);
    check("R12 pin idle", W'(pin_out[7]), 8'h00);
    wr(7, 8'h00);
  endtask

  task automatic t_edge_read();
    logic [W-1:0] d;
    idle(3);
    rd(5, d);
    @(negedge clk); pin_i = pin_i ^ 8'h04;
    @(negedge clk);
    @(negedge clk);
    addr = 3'd5; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    check("R7 read before edge", rdata, 8'h00);
    rd(5, d); check("R7 edge kept", d, 8'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_input();
    t_level_out();
    t_pulse_out();
    t_int_level();
    t_int_pulse();
    t_int_pin();
    t_edge_read();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule